// File: doc/BRIEF.md
# Bit-Manipulation Prefix Execution Unit

This unit carries out the rotate, shift, bit-test, bit-clear and bit-set instruction group that an 8-bit accumulator-style processor reaches through a one-byte prefix. The core hands it the byte that follows the prefix, together with a one-cycle `start` pulse. When the instruction is indexed, the core also supplies the signed displacement and names the index register to use. The unit then gets its operand from one of three places: the register file, the byte at the address in HL, or the byte at IX or IY plus the displacement.

The unit computes the new byte and the new flag byte. A register result goes back through a register-file write port, and a memory result goes back through a simple request/acknowledge byte port. The unit ends each instruction with a single `done` pulse. That pulse carries the register write, the flag write and the T-state count of the instruction.

Top module: `cbx_unit`

## Requirements
- R1: Opcode bits [2:0] select the operand: 0..5 select B, C, D, E, H, L and 7 selects A (this code also appears on `rf_rd_sel` and `rf_wr_sel`). Code 6 selects the memory byte at HL.
- R2: Opcode bits [7:3] select the operation. Codes 0..7 are RLC, RRC, RL, RR, SLA, SRA, SLL, SRL. Codes 8..15 are BIT 0..7, codes 16..23 are RES 0..7 and codes 24..31 are SET 0..7.
- R3: RLC and RRC move the bit that leaves the byte into both the carry and the opposite end of the byte. RL and RR rotate through the old carry.
- R4: SLA shifts in 0 at bit 0 and SLL shifts in 1 at bit 0. SRA keeps bit 7 and SRL shifts in 0 at bit 7. In every shift, the carry receives the bit that was shifted out.
- R5: Flag byte layout is S=bit7, Z=bit6, H=bit4, P/V=bit2, N=bit1, C=bit0. After a rotate or shift, S, Z and P come from the result, with P set when the result has an even number of ones. C gets the bit that left the byte, and all other flag bits are 0.
- R6: BIT b keeps C and sets H. It sets Z when the tested bit is 0, and sets S when the tested bit is 1 and b is 7. Every other flag bit becomes 0.
- R7: RES and SET write no flags (`flags_we` stays 0). They write the modified byte back to the register or memory byte that was read.
- R8: `tstates` at `done` is 8 for a register operand, 20 for BIT on memory and 23 for any other operation on memory.
- R9: In indexed mode (`idx_sel` 1 = IX, 2 or 3 = IY), the address is the index plus the sign-extended displacement. Opcode bits [2:0] are ignored there, and no register write takes place.
- R10: A memory request holds `mem_req`, `mem_addr` and `mem_we` until `mem_ack`. A memory BIT performs one read and no write. Any other memory operation performs one read, then one write to the same address.
- R11: `done` is a single-cycle pulse. For a register operand it rises two clock edges after `start` is sampled. `rf_wr_en` and `flags_we` are asserted only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 8 | Byte following the prefix |
| idx_sel | input | 2 | 0 plain, 1 IX-indexed, 2/3 IY-indexed |
| disp | input | 8 | Signed displacement for indexed forms |
| reg_hl | input | ADDR_W | HL contents |
| reg_ix | input | ADDR_W | IX contents |
| reg_iy | input | ADDR_W | IY contents |
| rf_rd_sel | output | 3 | Register read select (opcode bits [2:0]) |
| rf_rd_data | input | 8 | Register read data, sampled with start |
| flags_in | input | 8 | Current flag byte, sampled with start |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_sel | output | 3 | Register write select |
| rf_wr_data | output | 8 | Register write data |
| flags_we | output | 1 | Flag write strobe |
| flags_out | output | 8 | New flag byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | Instruction complete |
| tstates | output | 5 | Instruction T-state count, valid with done |

## Verification
Several operations are easy to confuse, and the bench sets each of them apart with its own test. RL and RR are run with a carry-in that differs from the bit leaving the byte, so a design that rotates without using the carry gives the wrong byte. SLL is checked against SLA, and SRA against SRL, on operands with bit 7 set, so a swapped fill bit shows up in the result. BIT is run with bit 7 set and cleared and with C preset, which catches an S flag raised for the wrong bit and a carry that is lost.

Indexed accesses use a negative displacement and register bits other than 6. This catches a design that adds the displacement without sign extension, and one that writes a register in indexed mode. Memory BIT is checked for the absence of a write cycle and for a count of 20, and RES/SET are checked for no flag write.

// File: rtl/cbx_pkg.sv
// Package: shared constants and types for the bit-manipulation prefix unit.
// Assumes the 8-bit flag layout S Z - H - P N C (bit 7 down to bit 0).
package cbx_pkg;
    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    // operation groups from opcode bits [7:6]
    localparam logic [1:0] GRP_SHF = 2'd0;
    localparam logic [1:0] GRP_BIT = 2'd1;
    localparam logic [1:0] GRP_RES = 2'd2;
    localparam logic [1:0] GRP_SET = 2'd3;

    localparam logic [2:0] SEL_MEM = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_CALC = 3'd2,
        ST_WR   = 3'd3,
        ST_FIN  = 3'd4
    } cbx_state_t;
endpackage

// File: rtl/cbx_alu.sv
// Module: cbx_alu
// Purely combinational datapath. Given the 5-bit operation code, an operand
// byte and the incoming flags, it produces the result byte and the new flags.
// Assumes the caller decides which of its outputs are committed.
module cbx_alu
    import cbx_pkg::*;
(
    input  logic [4:0] op,
    input  logic [7:0] a,
    input  logic [7:0] fin,
    output logic [7:0] res,
    output logic [7:0] fout
);
    logic       cin;
    logic       cout;
    logic       tested;
    logic [2:0] bsel;

    assign cin  = fin[FL_C];
    assign bsel = op[2:0];

    // Compute the result byte and the flag byte for the selected operation.
    always_comb begin
        res    = a;
        cout   = 1'b0;
        fout   = fin;
        tested = a[bsel];
        case (op[4:3])
            GRP_SHF: begin
                case (bsel)
                    3'd0: begin res = {a[6:0], a[7]}; cout = a[7]; end
                    3'd1: begin res = {a[0], a[7:1]}; cout = a[0]; end
                    3'd2: begin res = {a[6:0], cin};  cout = a[7]; end
                    3'd3: begin res = {cin, a[7:1]};  cout = a[0]; end
                    3'd4: begin res = {a[6:0], 1'b0}; cout = a[7]; end
                    3'd5: begin res = {a[7], a[7:1]}; cout = a[0]; end
                    3'd6: begin res = {a[6:0], 1'b1}; cout = a[7]; end
                    default: begin res = {1'b0, a[7:1]}; cout = a[0]; end
                endcase
                fout       = 8'h00;
                fout[FL_S] = res[7];
                fout[FL_Z] = (res == 8'h00);
                fout[FL_P] = ~(^res);
                fout[FL_C] = cout;
            end
            GRP_BIT: begin
                fout       = 8'h00;
                fout[FL_C] = cin;
                fout[FL_H] = 1'b1;
                fout[FL_Z] = ~tested;
                fout[FL_S] = tested & (bsel == 3'd7);
            end
            GRP_RES: res = a & ~(8'h01 << bsel);
            default: res = a | (8'h01 << bsel);
        endcase
    end
endmodule

// File: rtl/cbx_agen.sv
// Module: cbx_agen
// Forms the operand address: HL for plain forms, or IX/IY plus the
// sign-extended displacement for indexed forms. Combinational; the sequencer
// latches the address at start.
module cbx_agen #(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        idx_sel,
    input  logic [7:0]        disp,
    input  logic [ADDR_W-1:0] reg_hl,
    input  logic [ADDR_W-1:0] reg_ix,
    input  logic [ADDR_W-1:0] reg_iy,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - 8;

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement to the address width.
    assign disp_ext = {{EXT_W{disp[7]}}, disp};

    // Choose the base and add the displacement for indexed forms.
    always_comb begin
        case (idx_sel)
            2'd0:    addr = reg_hl;
            2'd1:    addr = reg_ix + disp_ext;
            default: addr = reg_iy + disp_ext;
        endcase
    end
endmodule

// File: rtl/cbx_seq.sv
// Module: cbx_seq
// Instruction sequencer: latches the instruction at start, runs the memory
// read / compute / write steps, and commits the results in a one-cycle
// done state. Assumes memory acknowledges each request after holding it.
module cbx_seq
    import cbx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TS_W      = 5,
    parameter int T_REG     = 8,
    parameter int T_MEM_BIT = 20,
    parameter int T_MEM_RMW = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [1:0]        idx_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        rf_rd_data,
    input  logic [7:0]        flags_in,
    input  logic [7:0]        alu_res,
    input  logic [7:0]        alu_flags,
    output logic [4:0]        op_q,
    output logic [7:0]        operand_q,
    output logic [7:0]        flags_q,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [7:0]        rf_wr_data,
    output logic              flags_we,
    output logic [7:0]        flags_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [TS_W-1:0]   tstates
);
    cbx_state_t        state;
    logic [2:0]        sel_q;
    logic              mem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        res_q;
    logic [7:0]        fres_q;
    logic              is_bit;
    logic              flag_op;

    assign is_bit  = (op_q[4:3] == GRP_BIT);
    assign flag_op = (op_q[4] == 1'b0);

    // State register and instruction/operand/result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            operand_q <= '0;
            flags_q   <= '0;
            sel_q     <= '0;
            mem_q     <= 1'b0;
            addr_q    <= '0;
            res_q     <= '0;
            fres_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q      <= opcode[7:3];
                    sel_q     <= opcode[2:0];
                    flags_q   <= flags_in;
                    operand_q <= rf_rd_data;
                    addr_q    <= addr_in;
                    mem_q     <= (idx_sel != 2'd0) || (opcode[2:0] == SEL_MEM);
                    state     <= ((idx_sel != 2'd0) || (opcode[2:0] == SEL_MEM))
                                 ? ST_RD : ST_CALC;
                end
                ST_RD: if (mem_ack) begin
                    operand_q <= mem_rdata;
                    state     <= ST_CALC;
                end
                ST_CALC: begin
                    res_q  <= alu_res;
                    fres_q <= alu_flags;
                    state  <= (mem_q && !is_bit) ? ST_WR : ST_FIN;
                end
                ST_WR: if (mem_ack) state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port during the read and write steps.
    always_comb begin
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = addr_q;
        mem_wdata = res_q;
    end

    // Commit register, flags and cycle count in the done state.
    always_comb begin
        done       = (state == ST_FIN);
        rf_wr_en   = done && !mem_q && !is_bit;
        rf_wr_sel  = sel_q;
        rf_wr_data = res_q;
        flags_we   = done && flag_op;
        flags_out  = fres_q;
        tstates    = '0;
        if (done) begin
            if (!mem_q)     tstates = TS_W'(T_REG);
            else if (is_bit) tstates = TS_W'(T_MEM_BIT);
            else            tstates = TS_W'(T_MEM_RMW);
        end
    end

    // R10: a pending request holds address and direction until acknowledged
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: register and flag writes happen only with done
    a_r11_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || flags_we) |-> done);

    // R9: no register write for a memory operand
    a_r9_no_rf_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && $past(mem_req)) |-> 1'b0);

    // R8: cycle count is one of the legal values whenever done
    a_r8_ts_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tstates == TS_W'(T_REG) || tstates == TS_W'(T_MEM_BIT)
                  || tstates == TS_W'(T_MEM_RMW)));
endmodule

// File: rtl/cbx_unit.sv
// Module: cbx_unit
// Top of the bit-manipulation prefix unit: address generator, sequencer and
// datapath. Assumes start is only raised while no instruction is running and
// that register data and flags are valid in the start cycle.
module cbx_unit #(
    parameter int ADDR_W    = 16,
    parameter int TS_W      = 5,
    parameter int T_REG     = 8,
    parameter int T_MEM_BIT = 20,
    parameter int T_MEM_RMW = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [1:0]        idx_sel,
    input  logic [7:0]        disp,
    input  logic [ADDR_W-1:0] reg_hl,
    input  logic [ADDR_W-1:0] reg_ix,
    input  logic [ADDR_W-1:0] reg_iy,
    output logic [2:0]        rf_rd_sel,
    input  logic [7:0]        rf_rd_data,
    input  logic [7:0]        flags_in,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [7:0]        rf_wr_data,
    output logic              flags_we,
    output logic [7:0]        flags_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [TS_W-1:0]   tstates
);
    logic [ADDR_W-1:0] addr_w;
    logic [4:0]        op_w;
    logic [7:0]        operand_w;
    logic [7:0]        flags_w;
    logic [7:0]        alu_res_w;
    logic [7:0]        alu_flags_w;

    assign rf_rd_sel = opcode[2:0];

    cbx_agen #(.ADDR_W(ADDR_W)) u_agen (
        .idx_sel (idx_sel),
        .disp    (disp),
        .reg_hl  (reg_hl),
        .reg_ix  (reg_ix),
        .reg_iy  (reg_iy),
        .addr    (addr_w)
    );

    cbx_alu u_alu (
        .op   (op_w),
        .a    (operand_w),
        .fin  (flags_w),
        .res  (alu_res_w),
        .fout (alu_flags_w)
    );

    cbx_seq #(
        .ADDR_W(ADDR_W), .TS_W(TS_W), .T_REG(T_REG),
        .T_MEM_BIT(T_MEM_BIT), .T_MEM_RMW(T_MEM_RMW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .idx_sel    (idx_sel),
        .addr_in    (addr_w),
        .rf_rd_data (rf_rd_data),
        .flags_in   (flags_in),
        .alu_res    (alu_res_w),
        .alu_flags  (alu_flags_w),
        .op_q       (op_w),
        .operand_q  (operand_w),
        .flags_q    (flags_w),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_sel  (rf_wr_sel),
        .rf_wr_data (rf_wr_data),
        .flags_we   (flags_we),
        .flags_out  (flags_out),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .done       (done),
        .tstates    (tstates)
    );

    // R6: a committed BIT result always has H set and N clear
    a_r6_bit_h: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && op_w[4:3] == 2'd1) |-> (flags_out[4] && !flags_out[1]));

    // R7: RES and SET never write flags
    a_r7_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_w[4]) |-> !flags_we);
endmodule

// File: tb/tb_cbx_unit.sv
// Directed bench for cbx_unit: one task per scenario, each checking itself.
module tb_cbx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [1:0]  idx_sel = 2'd0;
    logic [7:0]  disp = 8'h00;
    logic [15:0] reg_hl = 16'h1040;
    logic [15:0] reg_ix = 16'h2010;
    logic [15:0] reg_iy = 16'h3020;
    logic [2:0]  rf_rd_sel;
    logic [7:0]  rf_rd_data = 8'h00;
    logic [7:0]  flags_in = 8'h00;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [7:0]  rf_wr_data;
    logic        flags_we;
    logic [7:0]  flags_out;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ack = 1'b0;
    logic        done;
    logic [4:0]  tstates;

    int errors = 0;
    int checks = 0;
    int n_rd = 0;
    int n_wr = 0;
    int n_rfw = 0;
    int wait_cnt = 0;
    logic [15:0] last_wr_addr = 16'h0;
    logic [15:0] last_rd_addr = 16'h0;
    logic [7:0]  last_wr_data = 8'h0;
    logic [7:0]  mem [256];

    cbx_unit dut (.*);

    always #10 clk = ~clk;

    // Memory model: acknowledges every request on the second falling edge.
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wait_cnt == 1) begin
                wait_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    last_wr_addr = mem_addr; last_wr_data = mem_wdata; n_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[7:0]];
                    last_rd_addr = mem_addr; n_rd++;
                end
            end else wait_cnt++;
        end
    end

    // Count register writes.
    always @(posedge clk) if (rf_wr_en) n_rfw++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model from the requirement text: returns {result, flags}.
    function automatic logic [15:0] model(input logic [7:0] opc, input logic [7:0] v,
                                          input logic [7:0] f);
        logic [7:0] r;
        logic [7:0] nf;
        logic       co;
        int         k;
        k  = opc[5:3];
        r  = v;
        nf = f;
        co = 1'b0;
        if (opc[7:6] == 2'b00) begin
            case (k)
                0: begin co = v[7]; r = (v << 1) | {7'd0, v[7]}; end
                1: begin co = v[0]; r = (v >> 1) | {v[0], 7'd0}; end
                2: begin co = v[7]; r = (v << 1) | {7'd0, f[0]}; end
                3: begin co = v[0]; r = (v >> 1) | {f[0], 7'd0}; end
                4: begin co = v[7]; r = v << 1; end
                5: begin co = v[0]; r = (v >> 1) | (v & 8'h80); end
                6: begin co = v[7]; r = (v << 1) | 8'h01; end
                default: begin co = v[0]; r = v >> 1; end
            endcase
            nf = {r[7], r == 8'h00, 1'b0, 1'b0, 1'b0, ($countones(r) % 2 == 0), 1'b0, co};
        end else if (opc[7:6] == 2'b01) begin
            nf = {v[k] && k == 7, !v[k], 1'b0, 1'b1, 3'b000, f[0]};
        end else if (opc[7:6] == 2'b10) r = v & ~(8'h01 << k);
        else r = v | (8'h01 << k);
        return {r, nf};
    endfunction

    task automatic issue(input logic [7:0] opc, input logic [1:0] ix, input logic [7:0] d,
                         input logic [7:0] rv, input logic [7:0] f, output int lat);
        @(negedge clk);
        opcode = opc; idx_sel = ix; disp = d; rf_rd_data = rv; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
    endtask

    // Register-operand scenario: data, flags, select, count, latency.
    task automatic reg_case(input string tag, input logic [7:0] opc, input logic [7:0] v,
                            input logic [7:0] f);
        logic [15:0] e;
        int lat;
        int rfw0;
        e = model(opc, v, f);
        rfw0 = n_rfw;
        issue(opc, 2'd0, 8'h00, v, f, lat);
        chk({tag, " R11 latency"}, lat, 2);
        chk({tag, " R8 tstates"}, tstates, 8);
        chk({tag, " R1 wr_sel"}, rf_wr_sel, opc[2:0]);
        if (opc[7:6] == 2'b01) begin
            chk({tag, " R6 flags"}, flags_out, e[7:0]);
            chk({tag, " R6 flags_we"}, flags_we, 1);
            chk({tag, " R6 no rf write"}, rf_wr_en, 0);
        end else begin
            chk({tag, " R2 result"}, rf_wr_data, e[15:8]);
            chk({tag, " R1 rf_wr_en"}, rf_wr_en, 1);
            if (opc[7:6] == 2'b00) chk({tag, " R5 flags"}, flags_out, e[7:0]);
            else chk({tag, " R7 flags_we"}, flags_we, 0);
        end
        @(negedge clk);
        chk({tag, " R11 done pulse"}, done, 0);
        chk({tag, " R11 one rf write"}, n_rfw - rfw0, (opc[7:6] == 2'b01) ? 0 : 1);
    endtask

    // Memory-operand scenario (HL or indexed).
    task automatic mem_case(input string tag, input logic [7:0] opc, input logic [1:0] ix,
                            input logic [7:0] d, input logic [15:0] addr,
                            input logic [7:0] v, input logic [7:0] f);
        logic [15:0] e;
        int lat;
        int rd0;
        int wr0;
        int rfw0;
        mem[addr[7:0]] = v;
        e = model(opc, v, f);
        rd0 = n_rd; wr0 = n_wr; rfw0 = n_rfw;
        issue(opc, ix, d, 8'h5A, f, lat);
        chk({tag, " R8 tstates"}, tstates, (opc[7:6] == 2'b01) ? 20 : 23);
        chk({tag, " R9 read addr"}, last_rd_addr, addr);
        chk({tag, " R10 reads"}, n_rd - rd0, 1);
        if (opc[7:6] == 2'b01) begin
            chk({tag, " R10 no write"}, n_wr - wr0, 0);
            chk({tag, " R6 flags"}, flags_out, e[7:0]);
        end else begin
            chk({tag, " R10 writes"}, n_wr - wr0, 1);
            chk({tag, " R10 write addr"}, last_wr_addr, addr);
            chk({tag, " R7 mem data"}, mem[addr[7:0]], e[15:8]);
            if (opc[7:6] == 2'b00) chk({tag, " R5 flags"}, flags_out, e[7:0]);
            else chk({tag, " R7 flags_we"}, flags_we, 0);
        end
        @(negedge clk);
        chk({tag, " R9 no rf write"}, n_rfw - rfw0, 0);
    endtask

    task automatic reset_case();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("reset done", done, 0);
        chk("reset mem_req", mem_req, 0);
        chk("reset R11 rf_wr_en", rf_wr_en, 0);
        chk("reset R11 flags_we", flags_we, 0);
        rst_n = 1'b1;
    endtask

    task automatic rotate_cases();
        reg_case("R3 RLC B", 8'h00, 8'h81, 8'h00);
        reg_case("R3 RRC A", 8'h0F, 8'h01, 8'h00);
        reg_case("R3 RL C cin", 8'h11, 8'h40, 8'h01);
        reg_case("R3 RR D cin", 8'h1A, 8'h02, 8'h01);
        reg_case("R3 RL E zero", 8'h13, 8'h80, 8'h00);
    endtask

    task automatic shift_cases();
        reg_case("R4 SLA H", 8'h24, 8'hC1, 8'h01);
        reg_case("R4 SLL H", 8'h34, 8'hC1, 8'h00);
        reg_case("R4 SRA L", 8'h2D, 8'h81, 8'h00);
        reg_case("R4 SRL L", 8'h3D, 8'h81, 8'h00);
    endtask

    task automatic bit_cases();
        reg_case("R6 BIT7 set", 8'h7F, 8'h80, 8'h01);
        reg_case("R6 BIT7 clear", 8'h78, 8'h00, 8'hFE);
        reg_case("R6 BIT3 clear", 8'h5A, 8'hF7, 8'hFF);
        reg_case("R6 BIT0 set", 8'h41, 8'h01, 8'hFE);
    endtask

    task automatic res_set_cases();
        reg_case("R7 RES5 B", 8'hA8, 8'hFF, 8'h55);
        reg_case("R7 SET2 A", 8'hD7, 8'h00, 8'hAA);
    endtask

    task automatic memory_cases();
        mem_case("R1 HL RLC", 8'h06, 2'd0, 8'h00, 16'h1040, 8'h81, 8'h00);
        mem_case("R1 HL BIT7", 8'h7E, 2'd0, 8'h00, 16'h1040, 8'h80, 8'h01);
        mem_case("R9 IX neg SET0", 8'hC0, 2'd1, 8'hFE, 16'h200E, 8'h10, 8'h00);
        mem_case("R9 IY pos RES7", 8'hBB, 2'd2, 8'h7F, 16'h309F, 8'hFF, 8'h00);
        mem_case("R9 IY BIT2", 8'h52, 2'd3, 8'h80, 16'h2FA0, 8'h00, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        reset_case();
        rotate_cases();
        shift_cases();
        bit_cases();
        res_set_cases();
        memory_cases();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule